// File: doc/BRIEF.md
# Sigmoid Activation Lookup Unit

This unit turns a signed fixed-point activation value into the logistic function 1/(1+e^-x) without evaluating an exponential. Each sample arrives as a 16-bit word with one sign bit, five integer bits and ten fraction bits. The sample is snapped downward to a grid of 1/16, limited to the interval [-8, +8), and used directly as the address of a 256-entry table. The table entry comes back in the same fixed-point format. A value of 1.0 is therefore 0x0400 and 0.5 is 0x0200.

The table is filled at start-up by a loop inside the design. Each entry holds the logistic value at its grid point, scaled by 1024 and truncated. Samples below the table range give zero. Samples at or above +8 give exactly 1.0. One sample can be accepted on every clock. Each result appears with a valid flag exactly one clock after its sample, so the unit can sit directly behind a matrix-multiply array in a neural-network datapath.

Top module: `sigmoid_lut`

## Requirements
- R1: An input of 0x0000 (zero) produces exactly 0x0200 (0.5).
- R2: A result appears with `out_valid` high on the clock edge that follows the edge at which `in_valid` was high, and it belongs to the sample taken at that edge. Back-to-back samples give back-to-back results.
- R3: For an input from -8192 to 8191 (raw signed value), the output equals floor(1024 / (1 + e^-q)), where q = (x >>> 6) / 16. Every input within one 64-LSB step therefore gives the same output, and negative inputs round toward minus infinity.
- R4: The following points are exact: -0.0625 (0xFFC0) gives 0x01F0, -0.125 (0xFF80) gives 0x01E0, and +0.0625 (0x0040) gives 0x020F (0.5146484375).
- R5: Any input below -8.0 (raw value below -8192, i.e. below 0xE000 as a signed value) gives 0x0000.
- R6: Any input at or above +8.0 (raw value 0x2000 or more, as a signed value) gives 0x0400. The largest in-range input, 0x1FFF, gives 0x03FF.
- R7: The output never decreases when the input does not decrease.
- R8: A valid output never exceeds 0x0400 and is never negative.
- R9: A clock without `in_valid` leaves `out_valid` low on the next edge and leaves `out_data` unchanged.
- R10: While `rst` is high and after it is released, `out_valid` is 0 and `out_data` is 0x0000 until the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | 16 | Signed fixed-point sample, 10 fraction bits |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 16 | Logistic value, same fixed-point format |

## Verification
Every result, including the saturated ones, comes from one register stage. A sample driven at edge N is therefore checked on `out_data` at the falling edge after edge N+1. The bench drives on falling edges and reads one half period later. In the back-to-back sweep, the bench first reads the result of the previous sample and then drives the next one. This lets the monotonicity and table checks pair each output with the input taken one edge earlier. The hold and reset checks wait several idle edges and compare against the value that the last accepted sample set.

// File: rtl/sigm_pkg.sv
package sigm_pkg;

  // Which source feeds the output word for a captured sample.
  typedef enum logic [1:0] {
    ZONE_TABLE = 2'd0,
    ZONE_LOW   = 2'd1,
    ZONE_HIGH  = 2'd2
  } zone_e;

endpackage

// File: rtl/sigm_index.sv
module sigm_index
  import sigm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int STEP_SHIFT = 6,
  parameter int IDX_W      = 8
) (
  input  logic signed [DATA_W-1:0] x,
  output logic        [IDX_W-1:0]  idx,
  output zone_e                    zone
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int HALF    = ENTRIES / 2;
  localparam int LO_I    = -(HALF << STEP_SHIFT);
  localparam int HI_I    = (HALF << STEP_SHIFT) - 1;

  localparam logic signed [DATA_W-1:0] LO_S   = LO_I[DATA_W-1:0];
  localparam logic signed [DATA_W-1:0] HI_S   = HI_I[DATA_W-1:0];
  localparam logic signed [DATA_W-1:0] HALF_S = HALF[DATA_W-1:0];

  logic signed [DATA_W-1:0] stepped;

  always_comb begin
    stepped = x >>> STEP_SHIFT;
    if (x < LO_S) begin
      zone = ZONE_LOW;
      idx  = '0;
    end else if (x > HI_S) begin
      zone = ZONE_HIGH;
      idx  = '1;
    end else begin
      zone = ZONE_TABLE;
      idx  = IDX_W'(stepped + HALF_S);
    end
  end

endmodule

// File: rtl/sigm_rom.sv
module sigm_rom #(
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 10,
  parameter int STEP_SHIFT = 6,
  parameter int IDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  output logic [DATA_W-1:0] q
);

  localparam int  ENTRIES  = 1 << IDX_W;
  localparam int  HALF     = ENTRIES / 2;
  localparam int  PER_UNIT = 1 << (FRAC_W - STEP_SHIFT);
  localparam real ONE_R    = real'(1 << FRAC_W);

  logic [DATA_W-1:0] mem [ENTRIES];

  // Fill the table with floor(ONE * logistic(grid point)).
  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      real xv;
      real yv;
      xv = real'(i - HALF) / real'(PER_UNIT);
      yv = ONE_R / (1.0 + $exp(-xv));
      mem[i] = DATA_W'($rtoi(yv));
    end
  end

  // Registered read port with synchronous reset of the output latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (rd_en) begin
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/sigmoid_lut.sv
module sigmoid_lut
  import sigm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 10,
  parameter int STEP_SHIFT = 6,
  parameter int IDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [DATA_W-1:0] ONE_W = DATA_W'(1 << FRAC_W);

  logic [IDX_W-1:0]  idx;
  zone_e             zone_d;
  zone_e             zone_q;
  logic [DATA_W-1:0] rom_q;

  sigm_index #(
    .DATA_W     (DATA_W),
    .STEP_SHIFT (STEP_SHIFT),
    .IDX_W      (IDX_W)
  ) u_index (
    .x    ($signed(in_data)),
    .idx  (idx),
    .zone (zone_d)
  );

  sigm_rom #(
    .DATA_W     (DATA_W),
    .FRAC_W     (FRAC_W),
    .STEP_SHIFT (STEP_SHIFT),
    .IDX_W      (IDX_W)
  ) u_rom (
    .clk   (clk),
    .rst   (rst),
    .rd_en (in_valid),
    .addr  (idx),
    .q     (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_q    <= ZONE_TABLE;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        zone_q <= zone_d;
      end
    end
  end

  always_comb begin
    unique case (zone_q)
      ZONE_LOW:  out_data = '0;
      ZONE_HIGH: out_data = ONE_W;
      default:   out_data = rom_q;
    endcase
  end

endmodule

// File: rtl/sigmoid_lut_chk.sv
module sigmoid_lut_chk #(
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 10,
  parameter int STEP_SHIFT = 6,
  parameter int IDX_W      = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic        [DATA_W-1:0] out_data
);

  localparam int HALF_ENT = (1 << IDX_W) / 2;
  localparam int LO_I     = -(HALF_ENT << STEP_SHIFT);
  localparam int HI_I     = (HALF_ENT << STEP_SHIFT) - 1;

  localparam logic signed [DATA_W-1:0] LO_S  = LO_I[DATA_W-1:0];
  localparam logic signed [DATA_W-1:0] HI_S  = HI_I[DATA_W-1:0];
  localparam logic        [DATA_W-1:0] ONE_W = DATA_W'(1 << FRAC_W);
  localparam logic        [DATA_W-1:0] MID_W = DATA_W'(1 << (FRAC_W - 1));

  assert_zero_mid_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_data == MID_W));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_low_sat_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data < LO_S) |=> (out_data == '0));

  assert_high_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data > HI_S) |=> (out_data == ONE_W));

  assert_monotone_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $past(in_valid) && in_data >= $past(in_data))
      |=> (out_data >= $past(out_data)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= ONE_W));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

endmodule

bind sigmoid_lut sigmoid_lut_chk #(
  .DATA_W     (DATA_W),
  .FRAC_W     (FRAC_W),
  .STEP_SHIFT (STEP_SHIFT),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sigmoid_lut_tb.sv
`timescale 1ns/1ps
module sigmoid_lut_tb;

  localparam int NVEC = 16;
  localparam int WATCHDOG_NS = 500000;

  // Stimulus and expected results (raw 16-bit words).
  localparam logic [15:0] VEC_IN [NVEC] = '{
    16'h0000, // R1 zero
    16'h003F, // R3 same step as zero
    16'hFFC0, // R4 -0.0625
    16'hFFFF, // R3 rounds toward minus infinity
    16'hFF80, // R4 -0.125
    16'h0040, // R4 +0.0625
    16'h0400, // R3 +1.0
    16'hFC00, // R3 -1.0
    16'h0800, // R3 +2.0
    16'h1FFF, // R6 top of range
    16'h2000, // R6 +8.0
    16'h7FFF, // R6 most positive
    16'hE000, // R3 -8.0 (bottom entry)
    16'hDFFF, // R5 just below range
    16'h8000, // R5 most negative
    16'h0000  // R1 again after a saturated sample
  };
  localparam logic [15:0] VEC_EXP [NVEC] = '{
    16'h0200, 16'h0200, 16'h01F0, 16'h01F0, 16'h01E0, 16'h020F,
    16'h02EC, 16'h0113, 16'h0385, 16'h03FF, 16'h0400, 16'h0400,
    16'h0000, 16'h0000, 16'h0000, 16'h0200
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  sigmoid_lut u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic string vec_tag(int i);
    case (i)
      0, 15:           return "R1";
      2, 4, 5:         return "R4";
      9, 10, 11:       return "R6";
      13, 14:          return "R5";
      default:         return "R3";
    endcase
  endfunction

  // Reference from R3/R5/R6.
  function automatic logic [15:0] ref_val(logic signed [15:0] x);
    real qv;
    if (x < -16'sd8192) return 16'h0000;
    if (x > 16'sd8191)  return 16'h0400;
    qv = real'(int'(x >>> 6)) / 16.0;
    return 16'($rtoi(1024.0 / (1.0 + $exp(-qv))));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic one_sample(logic [15:0] x, string tag, logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, {16'd0, out_data}, {16'd0, exp});
  endtask

  initial begin
    #(WATCHDOG_NS);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] held;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10 data in reset", {16'd0, out_data}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10 data after reset", {16'd0, out_data}, 32'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      one_sample(VEC_IN[i], vec_tag(i), VEC_EXP[i]);
    end

    // R9: idle clocks hold the result and keep valid low
    one_sample(16'h0400, "R3 before hold", 16'h02EC);
    held = out_data;
    repeat (4) begin
      @(negedge clk);
      check("R9 valid idle", {31'd0, out_valid}, 32'd0);
      check("R9 data held", {16'd0, out_data}, {16'd0, held});
    end

    // R2/R3/R7/R8: back-to-back sweep across and beyond the table
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(-9216);
    prev     = 16'h0000;
    for (int v = -9216 + 17; v <= 9216; v += 17) begin
      logic [15:0] last_in;
      @(negedge clk);
      last_in = in_data;
      check("R2 back-to-back valid", {31'd0, out_valid}, 32'd1);
      check("R3 sweep value", {16'd0, out_data}, {16'd0, ref_val($signed(last_in))});
      n_checks++;
      if (out_data < prev) begin
        n_fail++;
        $display("FAIL R7: actual 0x%0h expected >= 0x%0h", out_data, prev);
      end
      n_checks++;
      if (out_data > 16'h0400) begin
        n_fail++;
        $display("FAIL R8: actual 0x%0h expected <= 0x0400", out_data);
      end
      prev    = out_data;
      in_data = 16'(v);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 sweep end", {16'd0, out_data}, 32'h0400);

    // R10: reset during traffic clears the output
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'h0800;
    rst      = 1'b1;
    @(negedge clk);
    check("R10 valid mid reset", {31'd0, out_valid}, 32'd0);
    check("R10 data mid reset", {16'd0, out_data}, 32'd0);
    in_valid = 1'b0;
    rst      = 1'b0;
    one_sample(16'hFF80, "R4 after reset", 16'h01E0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule